// File: doc/BRIEF.md
# Serial Transmitter with RS-485 Driver-Enable Timing

This block serialises bytes onto an asynchronous line for a half-duplex, RS-485 style bus. Around every transmission it raises a driver-enable output a programmable number of sample ticks before the start bit. After the final stop bit it holds that output high for a second programmable number of ticks, so the external transceiver owns the bus for exactly the window the frame needs.

A prescaler turns the system clock into sample ticks. Each bit lasts 8 or 16 ticks, and the lead and lag windows are counted in the same ticks. Bytes enter through a valid/ready handshake into a one-byte holding register. A byte that is waiting when a frame ends follows it directly, and the driver stays on. A byte that arrives while the lag window runs must wait: the driver turns off, and then a full new lead window passes before its start bit. Timing fields are captured only while the transmitter is disabled.

Top module: `rs485_uart_tx`

## Requirements
- R1: A frame is one low start bit, 8 data bits least significant first, then one high stop bit (`cfg_stop2`=0) or two (`cfg_stop2`=1). The line is high whenever no frame is being sent.
- R2: A sample tick occurs every `cfg_div` clock cycles (a value of 0 acts as 1). One bit lasts 16 ticks when `cfg_os8`=0 and 8 ticks when `cfg_os8`=1.
- R3: `de` rises exactly `cfg_lead` ticks before the falling edge of the start bit. With a lead of 0, both change on the same clock edge. The line is never low while `de` is low.
- R4: After the last stop bit of the last queued frame ends, `de` stays high for exactly `cfg_lag` ticks. With a lag of 0, `de` falls on the edge that ends the stop bit.
- R5: A byte is taken on a clock edge where `tx_valid` and `tx_ready` are both high. `tx_ready` is high while enabled and the holding register is empty, and it returns high once the held byte has moved into the shifter. A byte held when a frame ends starts its start bit immediately after the stop bits, with `de` kept high.
- R6: A byte accepted during the lag window does not shorten it. `de` falls when the lag ends, stays low for one tick, then rises again, and the start bit follows after a full lead window.
- R7: `tx_done` is a one-cycle pulse in the first cycle in which `de` reads low after a frame sequence. No pulse occurs between back-to-back frames.
- R8: The lead, lag, oversampling, stop-bit and divisor fields are captured only while `en` is low. Changes made while `en` is high have no effect on frames.
- R9: One cycle after `en` is low, `txd` is high and `de`, `busy` and `tx_ready` are low, and any held byte is dropped. `busy` is high while a byte is held or a lead, frame or lag is in progress, and it is low in the cycle `de` falls at the end.
- R10: While `rst_n` is low, `txd` is high and `de`, `busy` and `tx_done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| en | input | 1 | Transmitter enable; low aborts and unlocks configuration |
| tx_data | input | 8 | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Holding register can take a byte |
| cfg_lead | input | 5 | Driver-enable lead, in ticks |
| cfg_lag | input | 5 | Driver-enable lag, in ticks |
| cfg_os8 | input | 1 | 0: 16 ticks per bit, 1: 8 ticks per bit |
| cfg_stop2 | input | 1 | 0: one stop bit, 1: two |
| cfg_div | input | 16 | Clock cycles per sample tick |
| txd | output | 1 | Serial line |
| de | output | 1 | Driver enable, active high |
| busy | output | 1 | Byte held or transfer in progress |
| tx_done | output | 1 | One-cycle pulse when the driver is released |

## Verification
The hardest case to reach is a byte that arrives inside the lag window. The end of the stop bit is not visible on the line, because the line is already high. The bench therefore times the start bit's falling edge and computes the stop end from the bit length. It then offers the second byte two cycles into a six-tick lag. It checks the exact cycle `de` falls, the single low tick, and the fresh lead before the new start bit. Back-to-back frames are reached by offering a second byte as soon as `tx_ready` returns. The bench counts `tx_done` pulses across both frames.

// File: rtl/utx_pkg.sv
package utx_pkg;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_LEAD  = 2'd1,
    SQ_FRAME = 2'd2,
    SQ_LAG   = 2'd3
  } seq_t;

  // sample ticks that make one bit
  function automatic logic [4:0] bit_ticks(input logic os8);
    return os8 ? 5'd8 : 5'd16;
  endfunction

  // start + data + stop bits
  function automatic int frame_len(input int data_w, input logic stop2);
    return data_w + (stop2 ? 3 : 2);
  endfunction

endpackage

// File: rtl/utx_tick_gen.sv
module utx_tick_gen #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] lim;

  assign lim  = (div == '0) ? '0 : div - 1'b1;
  assign tick = en && (cnt == lim);

  always_ff @(posedge clk) begin
    if (!rst_n || !en) cnt <= '0;
    else if (tick)     cnt <= '0;
    else               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import utx_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              tick,
  input  logic              os8,
  input  logic              stop2,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  output logic              tx,
  output logic              frame_end
);
  localparam int SR_W  = DATA_W + 3;
  localparam int CNT_W = $clog2(SR_W + 1);

  logic [SR_W-1:0]  sreg;
  logic [CNT_W-1:0] bits_left;
  logic [4:0]       phase;
  logic             active, bit_end;

  assign active    = (bits_left != '0);
  assign bit_end   = tick && active && (phase == bit_ticks(os8) - 5'd1);
  assign frame_end = bit_end && (bits_left == CNT_W'(1));
  assign tx        = sreg[0];

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      sreg      <= '1;
      bits_left <= '0;
      phase     <= '0;
    end else if (load) begin
      sreg      <= {2'b11, data, 1'b0};
      bits_left <= CNT_W'(frame_len(DATA_W, stop2));
      phase     <= '0;
    end else if (bit_end) begin
      sreg      <= {1'b1, sreg[SR_W-1:1]};
      bits_left <= bits_left - 1'b1;
      phase     <= '0;
    end else if (tick && active) begin
      phase     <= phase + 5'd1;
    end
  end
endmodule

// File: rtl/utx_de_seq.sv
module utx_de_seq
  import utx_pkg::*;
#(
  parameter int DT_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            tick,
  input  logic            pending,
  input  logic [DT_W-1:0] lead,
  input  logic [DT_W-1:0] lag,
  input  logic            frame_end,
  output logic            load,
  output logic            de,
  output logic            done,
  output logic            idle
);
  seq_t            st;
  logic [DT_W-1:0] cnt;
  logic            lead_end, lag_end;

  assign lead_end = tick && (cnt == lead - 1'b1);
  assign lag_end  = tick && (cnt == lag - 1'b1);
  assign idle     = (st == SQ_IDLE);

  always_comb begin
    load = 1'b0;
    unique case (st)
      SQ_IDLE:  load = tick && pending && (lead == '0);
      SQ_LEAD:  load = lead_end;
      SQ_FRAME: load = frame_end && pending;
      default:  load = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      st   <= SQ_IDLE;
      cnt  <= '0;
      de   <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (st)
        SQ_IDLE: if (tick && pending) begin
          de  <= 1'b1;
          cnt <= '0;
          st  <= (lead == '0) ? SQ_FRAME : SQ_LEAD;
        end
        SQ_LEAD: if (lead_end) st <= SQ_FRAME;
                 else if (tick) cnt <= cnt + 1'b1;
        SQ_FRAME: if (frame_end && !pending) begin
          if (lag == '0) begin
            st   <= SQ_IDLE;
            de   <= 1'b0;
            done <= 1'b1;
          end else begin
            st  <= SQ_LAG;
            cnt <= '0;
          end
        end
        SQ_LAG: if (lag_end) begin
          st   <= SQ_IDLE;
          de   <= 1'b0;
          done <= 1'b1;
        end else if (tick) cnt <= cnt + 1'b1;
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rs485_uart_tx.sv
module rs485_uart_tx #(
  parameter int DATA_W = 8,
  parameter int DT_W   = 5,
  parameter int DIV_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  input  logic [DT_W-1:0]   cfg_lead,
  input  logic [DT_W-1:0]   cfg_lag,
  input  logic              cfg_os8,
  input  logic              cfg_stop2,
  input  logic [DIV_W-1:0]  cfg_div,
  output logic              txd,
  output logic              de,
  output logic              busy,
  output logic              tx_done
);
  logic [DT_W-1:0]   lead_q, lag_q;
  logic              os8_q, stop2_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] hold_data;
  logic              hold_full, accept, tick, load, frame_end, seq_idle;

  // configuration is open only while disabled
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lead_q  <= '0;
      lag_q   <= '0;
      os8_q   <= 1'b0;
      stop2_q <= 1'b0;
      div_q   <= '0;
    end else if (!en) begin
      lead_q  <= cfg_lead;
      lag_q   <= cfg_lag;
      os8_q   <= cfg_os8;
      stop2_q <= cfg_stop2;
      div_q   <= cfg_div;
    end
  end

  assign tx_ready = en && !hold_full;
  assign accept   = tx_valid && tx_ready;

  always_ff @(posedge clk) begin
    if (!rst_n || !en) begin
      hold_full <= 1'b0;
      hold_data <= '0;
    end else if (accept) begin
      hold_full <= 1'b1;
      hold_data <= tx_data;
    end else if (load) begin
      hold_full <= 1'b0;
    end
  end

  assign busy = hold_full || !seq_idle;

  utx_tick_gen #(.DIV_W(DIV_W)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(en), .div(div_q), .tick(tick)
  );

  utx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .os8(os8_q),
    .stop2(stop2_q), .load(load), .data(hold_data), .tx(txd),
    .frame_end(frame_end)
  );

  utx_de_seq #(.DT_W(DT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .tick(tick), .pending(hold_full),
    .lead(lead_q), .lag(lag_q), .frame_end(frame_end), .load(load),
    .de(de), .done(tx_done), .idle(seq_idle)
  );
endmodule

// File: rtl/utx_chk.sv
module utx_chk #(
  parameter int DT_W = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            en,
  input logic            txd,
  input logic            de,
  input logic            busy,
  input logic            tx_done,
  input logic            load,
  input logic [DT_W-1:0] lead_q
);
  // R9
  en_off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!de && txd && !busy));

  // R3
  line_low_needs_de_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !txd |-> de);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_done |=> !tx_done);

  // R7
  done_on_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(de) && $past(en)) |-> tx_done);

  // R8
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en && $past(en)) |-> $stable(lead_q));

  // R1
  load_starts_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !txd);
endmodule

bind rs485_uart_tx utx_chk #(.DT_W(DT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .txd(txd), .de(de), .busy(busy),
  .tx_done(tx_done), .load(load), .lead_q(lead_q)
);

// File: tb/tb_rs485_uart_tx.sv
module tb_rs485_uart_tx;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [7:0]  tx_data = '0;
  logic        tx_valid = 1'b0;
  logic        tx_ready;
  logic [4:0]  cfg_lead = '0, cfg_lag = '0;
  logic        cfg_os8 = 1'b0, cfg_stop2 = 1'b0;
  logic [15:0] cfg_div = 16'd1;
  logic        txd, de, busy, tx_done;

  int cyc = 0, checks = 0, errors = 0, done_cnt = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (tx_done) done_cnt <= done_cnt + 1;

  rs485_uart_tx dut (
    .clk(clk), .rst_n(rst_n), .en(en), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .cfg_lead(cfg_lead), .cfg_lag(cfg_lag), .cfg_os8(cfg_os8),
    .cfg_stop2(cfg_stop2), .cfg_div(cfg_div), .txd(txd), .de(de), .busy(busy),
    .tx_done(tx_done)
  );

  // data, lead, lag, os8, stop2, div
  localparam logic [35:0] VEC [0:5] = '{
    {8'hA5, 5'd3,  5'd2,  1'b0, 1'b0, 16'd2},
    {8'h3C, 5'd0,  5'd0,  1'b1, 1'b0, 16'd1},
    {8'h81, 5'd31, 5'd31, 1'b1, 1'b1, 16'd1},
    {8'hFF, 5'd1,  5'd0,  1'b0, 1'b1, 16'd3},
    {8'h00, 5'd0,  5'd5,  1'b1, 1'b0, 16'd0},
    {8'h5A, 5'd7,  5'd1,  1'b0, 1'b1, 16'd1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic wait_de(input logic v);
    while (de !== v) @(negedge clk);
  endtask

  task automatic wait_tx_low();
    while (txd !== 1'b0) @(negedge clk);
  endtask

  task automatic set_cfg(input int lead, input int lag, input bit os8,
                         input bit stop2, input int div);
    @(negedge clk);
    en = 1'b0;
    cfg_lead = 5'(lead); cfg_lag = 5'(lag); cfg_os8 = os8;
    cfg_stop2 = stop2; cfg_div = 16'(div);
    @(negedge clk);
    @(negedge clk);
    en = 1'b1;
  endtask

  task automatic offer(input logic [7:0] d);
    @(negedge clk);
    tx_valid = 1'b1;
    tx_data  = d;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  // R1 R2: sample every bit at its centre
  task automatic check_bits(input int t1, input logic [7:0] d, input int bitlen,
                            input int nb);
    for (int i = 0; i < nb; i++) begin
      logic e;
      e = (i == 0) ? 1'b0 : (i <= 8) ? d[i-1] : 1'b1;
      wait_cyc(t1 + i * bitlen + bitlen / 2);
      check(txd === e, $sformatf("R1 bit %0d", i), int'(txd), int'(e));
    end
  endtask

  task automatic measure(input logic [7:0] d, input int lead, input int lag,
                         input bit os8, input bit stop2, input int div);
    int t0, t1, t2, dv, osr, nb;
    dv  = (div == 0) ? 1 : div;
    osr = os8 ? 8 : 16;
    nb  = stop2 ? 11 : 10;
    wait_de(1'b1);   t0 = cyc;
    wait_tx_low();   t1 = cyc;
    check(t1 - t0 == lead * dv, "R3 lead", t1 - t0, lead * dv);
    check_bits(t1, d, osr * dv, nb);
    wait_de(1'b0);   t2 = cyc;
    check(t2 - t0 == (lead + nb * osr + lag) * dv, "R4 de span", t2 - t0,
          (lead + nb * osr + lag) * dv);
    check(tx_done === 1'b1, "R7 done at release", int'(tx_done), 1);
    check(busy === 1'b0, "R9 busy low at release", int'(busy), 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected 0", cyc);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int t0, t1, t1b, t2, t3, t4, base;
    repeat (3) @(negedge clk);
    // R10
    check(txd === 1'b1, "R10 txd", int'(txd), 1);
    check(de === 1'b0, "R10 de", int'(de), 0);
    check(busy === 1'b0, "R10 busy", int'(busy), 0);
    check(tx_done === 1'b0, "R10 done", int'(tx_done), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(tx_ready === 1'b0, "R9 ready while disabled", int'(tx_ready), 0);

    // table walk: R1 R2 R3 R4 R7
    for (int k = 0; k < 6; k++) begin
      set_cfg(int'(VEC[k][27:23]), int'(VEC[k][22:18]), VEC[k][17], VEC[k][16],
              int'(VEC[k][15:0]));
      fork
        offer(VEC[k][35:28]);
        measure(VEC[k][35:28], int'(VEC[k][27:23]), int'(VEC[k][22:18]),
                VEC[k][17], VEC[k][16], int'(VEC[k][15:0]));
      join
    end

    // R8: changes while enabled are ignored
    set_cfg(2, 0, 1'b1, 1'b0, 1);
    @(negedge clk);
    cfg_lead = 5'd9; cfg_lag = 5'd7; cfg_os8 = 1'b0; cfg_div = 16'd4;
    fork
      offer(8'hC3);
      measure(8'hC3, 2, 0, 1'b1, 1'b0, 1);
    join

    // R5 R7: back-to-back frames share one driver window
    set_cfg(2, 3, 1'b1, 1'b0, 1);
    base = done_cnt;
    fork
      begin offer(8'h12); offer(8'h34); end
      begin
        wait_de(1'b1);  t0 = cyc;
        wait_tx_low();  t1 = cyc;
        check(tx_ready === 1'b1 || tx_valid === 1'b1, "R5 ready after load",
              int'(tx_ready), 1);
        check_bits(t1, 8'h12, 8, 10);
        t1b = t1 + 80;
        wait_cyc(t1b);
        check(txd === 1'b0, "R5 second start follows stop", int'(txd), 0);
        check(de === 1'b1, "R5 de held between frames", int'(de), 1);
        check_bits(t1b, 8'h34, 8, 10);
        wait_de(1'b0);  t2 = cyc;
        check(t2 == t1b + 83, "R4 lag after last frame", t2 - t1b, 83);
      end
    join
    @(negedge clk);
    check(done_cnt - base == 1, "R7 single done", done_cnt - base, 1);

    // R6: byte offered inside the lag window
    set_cfg(4, 6, 1'b1, 1'b0, 1);
    offer(8'h56);
    wait_de(1'b1);  t0 = cyc;
    wait_tx_low();  t1 = cyc;
    check(t1 - t0 == 4, "R3 lead", t1 - t0, 4);
    wait_cyc(t1 + 82);
    offer(8'h9A);
    wait_de(1'b0);  t2 = cyc;
    check(t2 == t1 + 86, "R6 lag not shortened", t2 - t1, 86);
    check(tx_done === 1'b1, "R7 done at release", int'(tx_done), 1);
    wait_de(1'b1);  t3 = cyc;
    check(t3 == t2 + 1, "R6 one tick low", t3 - t2, 1);
    wait_tx_low();  t4 = cyc;
    check(t4 - t3 == 4, "R6 fresh lead", t4 - t3, 4);
    check_bits(t4, 8'h9A, 8, 10);
    wait_de(1'b0);

    // R9: disable in mid-frame
    set_cfg(0, 0, 1'b0, 1'b0, 1);
    offer(8'h77);
    wait_tx_low();
    wait_cyc(cyc + 20);
    @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    check(txd === 1'b1, "R9 txd idle", int'(txd), 1);
    check(de === 1'b0, "R9 de off", int'(de), 0);
    check(busy === 1'b0, "R9 busy off", int'(busy), 0);
    check(tx_ready === 1'b0, "R9 ready off", int'(tx_ready), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule